// File: doc/BRIEF.md
# PS/2 Host Port Controller

This block is the host end of a two-wire PS/2 link. The clock and data lines come in from open-drain pads and pass through a synchroniser, and the block finds the falling edges of the clock. A receive engine assembles frames that the device clocks out. A transmit engine runs a host-to-device transfer. First it holds the clock line low, then it sets a start request, then it shifts a byte out on the clock pulses that the device returns. Software sees three byte-wide registers: a data register, a control register and a status register.

The control register selects the direction (receive or transmit) and turns the port on or off. It also selects how the receiver treats the parity bit and the stop bit. The status register carries a ready flag, which a read of the data register clears. It also carries live indicators for an idle transmitter and a reception in progress. Five sticky flags report parity errors, stop-bit errors and three kinds of timeout, and writing 1 to a flag clears it. The pads are driven through two active-high pull-low enables.

Top module: `ps2h_port`

## Requirements
- R1: After reset the status register reads 0x10 (only transmitter-idle set), and the control and data registers read 0. No line is pulled low.
- R2: A received frame is a start bit of 0, eight data bits with the LSB first, a parity bit and a stop bit. Each bit is sampled on a falling edge of the synchronised clock. When the eleventh edge arrives the byte is loaded into the data register and status bit 0 (ready) is set.
- R3: The data register is at offset 0x0, control at 0x4 and status at 0x8. Control bit 0 is the direction (1 = transmit), bit 1 is enable, [3:2] is the parity mode and [5:4] is the stop mode. Control reads back its six bits, and the upper bits read as 0.
- R4: A read of the data register clears the ready flag.
- R5: The parity mode uses 0 for odd and 1 for even; 2 and 3 turn the check off. A data-plus-parity count that does not match the selected mode sets status bit 2.
- R6: The stop mode uses 0 to expect a 1 and 1 to expect a 0; 2 and 3 turn the check off. A stop bit that does not match sets status bit 3.
- R7: Status bits 1, 2, 3, 5 and 7 are cleared by writing 1 to them. Writing to bits 0, 4 and 6 has no effect.
- R8: Within a frame, a gap of RX_TMO_CYC cycles with no clock edge sets status bit 1 and returns the receiver to idle, and the next complete frame is received normally.
- R9: Status bit 6 is high from the start bit until the frame ends or times out.
- R10: When the port is enabled in transmit direction and idle, a write to the data register clears status bit 4 and pulls the clock line low for INHIBIT_CYC cycles. While the transmitter is idle, no line is pulled low.
- R11: After the inhibit, the data line is pulled low and the clock is released. The device reads the bits on its rising edges: start 0, data LSB first, parity (odd, or even in even mode) and stop 1. The twelfth falling edge returns the transmitter to idle.
- R12: If no device clock edge arrives within TX_START_TMO_CYC cycles of the start request, status bit 7 is set and both lines are released.
- R13: During a transfer, a gap of TX_TMO_CYC cycles between clock edges sets status bit 5 and ends the transfer.
- R14: With the port disabled, or in transmit direction, incoming frames do not change the data register or the ready and busy flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| ps2_clk_i | input | 1 | PS/2 clock line level |
| ps2_dat_i | input | 1 | PS/2 data line level |
| ps2_clk_oe_o | output | 1 | Pull clock line low |
| ps2_dat_oe_o | output | 1 | Pull data line low |

## Verification
The bench targets the mode corners where a polarity or code mix-up passes silently on good frames. These are frames with deliberately wrong parity and stop bits in each mode, and the same frames with checking turned off, so that a swapped odd/even test or an ignored "off" code shows up as a missing or spurious error flag. It cuts a frame short after three bits: a receiver that never times out stays busy and misreads the next frame. It also stalls the device clock both before and during a transmit: a transmitter without those timeouts never returns to idle. It collects the transmitted bits the way a device samples them, so an off-by-one in the falling-edge count shows up as shifted data, a missing start bit or a stop bit of the wrong level.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_DATA = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h8;

  localparam logic [1:0] PAR_ODD  = 2'd0;
  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] STP_HIGH = 2'd0;
  localparam logic [1:0] STP_LOW  = 2'd1;

  typedef struct packed {
    logic [1:0] stop;
    logic [1:0] par;
    logic       en;
    logic       dir;
  } ctrl_t;

  typedef enum logic [1:0] {TX_IDLE, TX_INHIBIT, TX_WAIT, TX_SHIFT} tx_state_e;
endpackage

// File: rtl/ps2h_sync.sv
module ps2h_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_line_i,
  input  logic dat_line_i,
  output logic fall_o,
  output logic dat_o
);
  localparam int unsigned MSB = STAGES - 1;
  logic [MSB:0] clk_q, dat_q;
  logic         clk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q      <= '1;
      dat_q      <= '1;
      clk_prev_q <= 1'b1;
    end else begin
      clk_q      <= {clk_q[MSB-1:0], clk_line_i};
      dat_q      <= {dat_q[MSB-1:0], dat_line_i};
      clk_prev_q <= clk_q[MSB];
    end
  end

  assign fall_o = clk_prev_q & ~clk_q[MSB];
  assign dat_o  = dat_q[MSB];
endmodule

// File: rtl/ps2h_rx.sv
module ps2h_rx import ps2h_pkg::*; #(
  parameter int unsigned TMO_CYC = 9600
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       fall_i,
  input  logic       dat_i,
  input  logic [1:0] par_mode_i,
  input  logic [1:0] stop_mode_i,
  output logic       done_o,
  output logic [7:0] byte_o,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       tmo_o,
  output logic       busy_o
);
  localparam int unsigned TW = $clog2(TMO_CYC + 1);

  logic [3:0]    cnt_q;
  logic [7:0]    sh_q;
  logic          par_q;
  logic [TW-1:0] tmr_q;
  logic          odd9, par_bad, stop_bad;

  assign odd9     = ^{sh_q, par_q};
  assign par_bad  = (par_mode_i == PAR_ODD)  ? ~odd9 :
                    (par_mode_i == PAR_EVEN) ?  odd9 : 1'b0;
  assign stop_bad = (stop_mode_i == STP_HIGH) ? ~dat_i :
                    (stop_mode_i == STP_LOW)  ?  dat_i : 1'b0;
  assign busy_o   = (cnt_q != 4'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      tmr_q  <= '0;
      done_o <= 1'b0;
      byte_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
      tmo_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      tmo_o  <= 1'b0;
      if (!en_i) begin
        cnt_q <= '0;
        tmr_q <= '0;
      end else if (fall_i) begin
        tmr_q <= '0;
        case (cnt_q)
          4'd0:  if (!dat_i) cnt_q <= 4'd1;
          4'd9:  begin par_q <= dat_i; cnt_q <= 4'd10; end
          4'd10: begin
            done_o <= 1'b1;
            byte_o <= sh_q;
            perr_o <= par_bad;
            ferr_o <= stop_bad;
            cnt_q  <= '0;
          end
          default: begin
            sh_q  <= {dat_i, sh_q[7:1]};
            cnt_q <= cnt_q + 4'd1;
          end
        endcase
      end else if (busy_o) begin
        if (tmr_q >= TW'(TMO_CYC - 1)) begin
          tmo_o <= 1'b1;
          cnt_q <= '0;
          tmr_q <= '0;
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
      end
    end
  end

  assert_tmo_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> !busy_o);
  assert_off_idle_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o);
endmodule

// File: rtl/ps2h_tx.sv
module ps2h_tx import ps2h_pkg::*; #(
  parameter int unsigned INHIBIT_CYC      = 4800,
  parameter int unsigned TX_START_TMO_CYC = 720000,
  parameter int unsigned TX_TMO_CYC       = 96000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic [1:0] par_mode_i,
  input  logic       fall_i,
  output logic       clk_oe_o,
  output logic       dat_oe_o,
  output logic       idle_o,
  output logic       sttmo_o,
  output logic       tmo_o
);
  localparam int unsigned M1   = (INHIBIT_CYC > TX_START_TMO_CYC) ? INHIBIT_CYC : TX_START_TMO_CYC;
  localparam int unsigned TMAX = (M1 > TX_TMO_CYC) ? M1 : TX_TMO_CYC;
  localparam int unsigned TW   = $clog2(TMAX + 1);

  tx_state_e     st_q;
  logic [TW-1:0] tmr_q;
  logic [3:0]    cnt_q;
  logic [9:0]    sh_q;
  logic          par_bit;

  assign par_bit  = (par_mode_i == PAR_EVEN) ? ^byte_i : ~^byte_i;
  assign clk_oe_o = (st_q == TX_INHIBIT);
  assign idle_o   = (st_q == TX_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= TX_IDLE;
      tmr_q    <= '0;
      cnt_q    <= '0;
      sh_q     <= '1;
      dat_oe_o <= 1'b0;
      sttmo_o  <= 1'b0;
      tmo_o    <= 1'b0;
    end else begin
      sttmo_o <= 1'b0;
      tmo_o   <= 1'b0;
      if (!en_i) begin
        st_q     <= TX_IDLE;
        tmr_q    <= '0;
        dat_oe_o <= 1'b0;
      end else begin
        case (st_q)
          TX_IDLE: if (start_i) begin
            sh_q  <= {1'b1, par_bit, byte_i};
            tmr_q <= '0;
            st_q  <= TX_INHIBIT;
          end
          TX_INHIBIT: begin
            if (tmr_q >= TW'(INHIBIT_CYC - 1)) begin
              tmr_q    <= '0;
              dat_oe_o <= 1'b1;
              st_q     <= TX_WAIT;
            end else tmr_q <= tmr_q + 1'b1;
          end
          TX_WAIT: begin
            if (fall_i) begin
              tmr_q <= '0;
              cnt_q <= 4'd1;
              st_q  <= TX_SHIFT;
            end else if (tmr_q >= TW'(TX_START_TMO_CYC - 1)) begin
              sttmo_o  <= 1'b1;
              dat_oe_o <= 1'b0;
              st_q     <= TX_IDLE;
            end else tmr_q <= tmr_q + 1'b1;
          end
          default: begin
            if (fall_i) begin
              tmr_q <= '0;
              cnt_q <= cnt_q + 4'd1;
              if (cnt_q == 4'd11) begin
                dat_oe_o <= 1'b0;
                st_q     <= TX_IDLE;
              end else begin
                dat_oe_o <= ~sh_q[0];
                sh_q     <= {1'b1, sh_q[9:1]};
              end
            end else if (tmr_q >= TW'(TX_TMO_CYC - 1)) begin
              tmo_o    <= 1'b1;
              dat_oe_o <= 1'b0;
              st_q     <= TX_IDLE;
            end else tmr_q <= tmr_q + 1'b1;
          end
        endcase
      end
    end
  end

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (!clk_oe_o && !dat_oe_o));
  assert_request_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == TX_WAIT && $past(st_q) == TX_INHIBIT) |-> (dat_oe_o && !clk_oe_o));
  assert_sttmo_release_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sttmo_o |-> (idle_o && !dat_oe_o));
endmodule

// File: rtl/ps2h_port.sv
module ps2h_port import ps2h_pkg::*; #(
  parameter int unsigned SYNC_STAGES      = 2,
  parameter int unsigned INHIBIT_CYC      = 4800,
  parameter int unsigned RX_TMO_CYC       = 9600,
  parameter int unsigned TX_START_TMO_CYC = 720000,
  parameter int unsigned TX_TMO_CYC       = 96000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              ps2_clk_i,
  input  logic              ps2_dat_i,
  output logic              ps2_clk_oe_o,
  output logic              ps2_dat_oe_o
);
  ctrl_t      ctrl_q;
  logic [7:0] rx_data_q;
  logic       rdy_q, rxtmo_q, pe_q, fe_q, txtmo_q, txsttmo_q;
  logic       fall, sdat;
  logic       rx_done, rx_perr, rx_ferr, rx_tmo, rx_busy;
  logic [7:0] rx_byte;
  logic       tx_idle, tx_sttmo, tx_tmo, tx_start;
  logic       wr_data, wr_ctrl, wr_stat, rd_data;

  assign wr_data  = reg_wr_i && (reg_addr_i == OFS_DATA);
  assign wr_ctrl  = reg_wr_i && (reg_addr_i == OFS_CTRL);
  assign wr_stat  = reg_wr_i && (reg_addr_i == OFS_STAT);
  assign rd_data  = reg_rd_i && (reg_addr_i == OFS_DATA);
  assign tx_start = wr_data && ctrl_q.en && ctrl_q.dir && tx_idle;

  ps2h_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .clk_line_i(ps2_clk_i), .dat_line_i(ps2_dat_i),
    .fall_o(fall), .dat_o(sdat)
  );

  ps2h_rx #(.TMO_CYC(RX_TMO_CYC)) u_rx (
    .clk_i, .rst_ni, .en_i(ctrl_q.en && !ctrl_q.dir), .fall_i(fall), .dat_i(sdat),
    .par_mode_i(ctrl_q.par), .stop_mode_i(ctrl_q.stop),
    .done_o(rx_done), .byte_o(rx_byte), .perr_o(rx_perr), .ferr_o(rx_ferr),
    .tmo_o(rx_tmo), .busy_o(rx_busy)
  );

  ps2h_tx #(.INHIBIT_CYC(INHIBIT_CYC), .TX_START_TMO_CYC(TX_START_TMO_CYC),
            .TX_TMO_CYC(TX_TMO_CYC)) u_tx (
    .clk_i, .rst_ni, .en_i(ctrl_q.en && ctrl_q.dir), .start_i(tx_start),
    .byte_i(reg_wdata_i), .par_mode_i(ctrl_q.par), .fall_i(fall),
    .clk_oe_o(ps2_clk_oe_o), .dat_oe_o(ps2_dat_oe_o), .idle_o(tx_idle),
    .sttmo_o(tx_sttmo), .tmo_o(tx_tmo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      rx_data_q <= '0;
      rdy_q     <= 1'b0;
      rxtmo_q   <= 1'b0;
      pe_q      <= 1'b0;
      fe_q      <= 1'b0;
      txtmo_q   <= 1'b0;
      txsttmo_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata_i[5:0]);
      if (rx_done) begin
        rx_data_q <= rx_byte;
        rdy_q     <= 1'b1;
      end else if (rd_data) rdy_q <= 1'b0;
      // sticky: a set in the same cycle wins over a clear
      rxtmo_q   <= rx_tmo   | (rxtmo_q   & ~(wr_stat & reg_wdata_i[1]));
      pe_q      <= (rx_done & rx_perr) | (pe_q & ~(wr_stat & reg_wdata_i[2]));
      fe_q      <= (rx_done & rx_ferr) | (fe_q & ~(wr_stat & reg_wdata_i[3]));
      txtmo_q   <= tx_tmo   | (txtmo_q   & ~(wr_stat & reg_wdata_i[5]));
      txsttmo_q <= tx_sttmo | (txsttmo_q & ~(wr_stat & reg_wdata_i[7]));
    end
  end

  always_comb begin
    case (reg_addr_i)
      OFS_DATA: reg_rdata_o = rx_data_q;
      OFS_CTRL: reg_rdata_o = {2'b00, ctrl_q};
      OFS_STAT: reg_rdata_o = {txsttmo_q, rx_busy, txtmo_q, tx_idle,
                               fe_q, pe_q, rxtmo_q, rdy_q};
      default:  reg_rdata_o = 8'h00;
    endcase
  end

  assert_ready_on_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done |=> rdy_q);
  assert_w1c_parity_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && reg_wdata_i[2] && !(rx_done && rx_perr)) |=> !pe_q);
endmodule

// File: tb/tb_ps2h_port.sv
module tb_ps2h_port;
  localparam int CLK_PERIOD = 10;
  localparam int INH = 50, RXT = 200, STT = 300, TXT = 200;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       dev_clk = 1'b1, dev_dat = 1'b1;
  logic       clk_oe, dat_oe, line_clk, line_dat;
  int         n_chk = 0, n_fail = 0, cyc = 0;
  bit         done = 1'b0;

  typedef struct {logic [7:0] data; logic [7:0] stat; string req;} exp_t;
  exp_t sb[$];

  assign line_clk = dev_clk & ~clk_oe;
  assign line_dat = dev_dat & ~dat_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2h_port #(.INHIBIT_CYC(INH), .RX_TMO_CYC(RXT), .TX_START_TMO_CYC(STT),
              .TX_TMO_CYC(TXT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ps2_clk_i(line_clk),
    .ps2_dat_i(line_dat), .ps2_clk_oe_o(clk_oe), .ps2_dat_oe_o(dat_oe)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    dev_dat = b; waitc(10);
    dev_clk = 1'b0; waitc(20);
    dev_clk = 1'b1; waitc(10);
  endtask

  // driver: sends a device frame and queues the expected register view
  task automatic rx_frame(input logic [7:0] b, input logic p, input logic s,
                          input logic [7:0] stat, input string req);
    exp_t e;
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit(p);
    send_bit(s);
    dev_dat = 1'b1; waitc(5);
    e.data = b; e.stat = stat; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: pops and compares status, data and the ready clear
  task automatic rx_check();
    exp_t e;
    logic [7:0] v;
    e = sb.pop_front();
    reg_rd(4'h8, v); chk({e.req, " status"}, {8'h0, v}, {8'h0, e.stat});
    if (e.stat[0]) begin
      reg_rd(4'h0, v); chk({e.req, " data"}, {8'h0, v}, {8'h0, e.data});
      reg_rd(4'h8, v); chk("R4 ready cleared by read", {8'h0, v[0]}, 16'h0);
    end
  endtask

  task automatic dev_tx(input int pulses, output logic [10:0] got);
    got = '0;
    for (int k = 1; k <= pulses; k++) begin
      if (k == 12) dev_dat = 1'b0;
      waitc(10);
      dev_clk = 1'b0; waitc(19);
      if (k <= 11) got[k-1] = line_dat;
      waitc(1);
      dev_clk = 1'b1; waitc(10);
    end
    dev_dat = 1'b1;
  endtask

  task automatic wait_req();
    int n = 0;
    while (!(dat_oe && !clk_oe) && n < 1000) begin waitc(1); n++; end
  endtask

  initial begin
    logic [7:0]  v;
    logic [10:0] got;
    waitc(3); rst_n = 1'b1; waitc(2);

    reg_rd(4'h8, v); chk("R1 status after reset", {8'h0, v}, 16'h10);
    reg_rd(4'h4, v); chk("R1 control after reset", {8'h0, v}, 16'h0);
    reg_rd(4'h0, v); chk("R1 data after reset", {8'h0, v}, 16'h0);
    chk("R1 lines released", {14'h0, clk_oe, dat_oe}, 16'h0);

    reg_wr(4'h4, 8'hFA);
    reg_rd(4'h4, v); chk("R3 control readback", {8'h0, v}, 16'h3A);
    reg_wr(4'h4, 8'h02);

    rx_frame(8'hA5, ~^8'hA5, 1'b1, 8'h11, "R2 odd frame A5"); rx_check();
    rx_frame(8'h3C, ~^8'h3C, 1'b1, 8'h11, "R2 frame 3C lsb first"); rx_check();

    rx_frame(8'h01, 1'b1, 1'b1, 8'h15, "R5 odd mode bad parity");
    reg_wr(4'h8, 8'h51);
    rx_check();
    reg_rd(4'h8, v); chk("R7 pe held after ignored bits", {8'h0, v}, 16'h14);
    reg_wr(4'h8, 8'h04);
    reg_rd(4'h8, v); chk("R7 pe cleared by write 1", {8'h0, v}, 16'h10);

    reg_wr(4'h4, 8'h06);
    rx_frame(8'h01, 1'b1, 1'b1, 8'h11, "R5 even mode good parity"); rx_check();
    rx_frame(8'h01, 1'b0, 1'b1, 8'h15, "R5 even mode bad parity"); rx_check();
    reg_wr(4'h8, 8'h04);
    reg_wr(4'h4, 8'h0A);
    rx_frame(8'h01, 1'b0, 1'b1, 8'h11, "R5 parity off"); rx_check();

    reg_wr(4'h4, 8'h12);
    rx_frame(8'h81, ~^8'h81, 1'b1, 8'h19, "R6 low stop expected high seen"); rx_check();
    reg_wr(4'h8, 8'h08);
    rx_frame(8'h81, ~^8'h81, 1'b0, 8'h11, "R6 low stop good"); rx_check();
    reg_wr(4'h4, 8'h22);
    rx_frame(8'h42, ~^8'h42, 1'b0, 8'h11, "R6 stop check off"); rx_check();

    reg_wr(4'h4, 8'h02);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    reg_rd(4'h8, v); chk("R9 busy mid frame", {8'h0, v}, 16'h50);
    waitc(RXT + 50);
    reg_rd(4'h8, v); chk("R8 rx timeout flag", {8'h0, v}, 16'h12);
    reg_wr(4'h8, 8'h02);
    rx_frame(8'h77, ~^8'h77, 1'b1, 8'h11, "R8 frame after timeout"); rx_check();

    reg_wr(4'h4, 8'h00);
    rx_frame(8'h99, ~^8'h99, 1'b1, 8'h10, "R14 disabled ignores frame"); rx_check();
    reg_rd(4'h0, v); chk("R14 data unchanged when off", {8'h0, v}, 16'h77);
    reg_wr(4'h4, 8'h03);
    rx_frame(8'h99, ~^8'h99, 1'b1, 8'h10, "R14 tx dir ignores frame"); rx_check();

    reg_wr(4'h0, 8'h5A);
    waitc(5);
    reg_rd(4'h8, v); chk("R10 tx busy", {8'h0, v}, 16'h00);
    chk("R10 clock held low", {15'h0, clk_oe}, 16'h1);
    waitc(INH - 20);
    chk("R10 still inhibiting", {15'h0, clk_oe}, 16'h1);
    wait_req();
    chk("R11 request state", {14'h0, clk_oe, dat_oe}, 16'h1);
    dev_tx(12, got);
    chk("R11 odd tx bits", {5'h0, got}, {5'h0, 1'b1, ~^8'h5A, 8'h5A, 1'b0});
    waitc(10);
    reg_rd(4'h8, v); chk("R11 idle after ack", {8'h0, v}, 16'h10);
    chk("R10 lines released", {14'h0, clk_oe, dat_oe}, 16'h0);

    reg_wr(4'h4, 8'h07);
    reg_wr(4'h0, 8'h5A);
    wait_req();
    dev_tx(12, got);
    chk("R11 even tx bits", {5'h0, got}, {5'h0, 1'b1, ^8'h5A, 8'h5A, 1'b0});
    waitc(10);

    reg_wr(4'h4, 8'h03);
    reg_wr(4'h0, 8'hC3);
    waitc(INH + STT + 100);
    reg_rd(4'h8, v); chk("R12 start timeout", {8'h0, v}, 16'h90);
    chk("R12 lines released", {14'h0, clk_oe, dat_oe}, 16'h0);
    reg_wr(4'h8, 8'h80);

    reg_wr(4'h0, 8'hC3);
    wait_req();
    dev_tx(2, got);
    waitc(TXT + 100);
    reg_rd(4'h8, v); chk("R13 tx timeout", {8'h0, v}, 16'h30);
    reg_wr(4'h8, 8'h20);
    reg_rd(4'h8, v); chk("R7 tx timeout cleared", {8'h0, v}, 16'h10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule